// File: doc/BRIEF.md
# External Bus Release Arbiter

This block hands the processor's external bus to an outside bus master on request. It sits between the CPU's bus-cycle sequencer and the pin drivers. An active-low request pin is looked at only on clocks where the sequencer marks the start of a bus state. Two low looks in a row qualify the request. The block then waits until any CPU access in progress has reached its final state. At that point it drives an active-low acknowledge and turns off the drive enables of every external bus pin.

While the bus is handed over, a stall output keeps the CPU from starting new external accesses. The request keeps being sampled during that time. When it is seen high, the acknowledge returns high. The stall and the pin enables are released one clock later.

The state machine has five states:

- `ST_OWN`: the CPU owns the bus.
- `ST_QUAL`: one low sample has been seen.
- `ST_DRAIN`: the request is committed, and the block is waiting for the CPU access to finish.
- `ST_GRANT`: the bus is released.
- `ST_RECLAIM`: the acknowledge is high and the pins are still off, for one clock.

It has eight transitions:

- OWN→QUAL on a low sample.
- QUAL→OWN on a high sample.
- QUAL→GRANT on a low sample when the CPU is idle or its access ends at that boundary.
- QUAL→DRAIN on a low sample while an access continues.
- DRAIN→GRANT at the boundary where the access ends.
- GRANT→RECLAIM on a high sample.
- RECLAIM→OWN on the next clock, unconditionally.
- OWN stays in OWN on a high sample.

Top module: `ext_bus_release`

## Requirements
- R1: After reset, `bus_ack_n` is 1, `cpu_stall` is 0, and every enable output is all ones (1 = drive, 0 = high impedance). No earlier request samples are remembered.
- R2: `bus_req_n` is sampled only on clocks with `state_edge` = 1. On other clocks no output changes, except for the one-clock exit from reclaim (R7).
- R3: A low sample followed by a high sample returns to `ST_OWN` with no release. A fresh pair of consecutive low samples is then needed.
- R4: If `acc_busy` is 0 when the second consecutive low sample is taken, `bus_ack_n` goes low right after that edge. This is never earlier than the second state boundary after the request fell.
- R5: If an access is in progress at the qualifying sample and is not in its final state (`acc_busy` = 1, `acc_final` = 0), the acknowledge waits for a boundary with `acc_final` = 1 or `acc_busy` = 0.
- R6: While `bus_ack_n` is 0, every enable output (address, data, all eight chip selects, address strobe, read strobe, both write strobes) is all zeros.
- R7: A high sample while released drives `bus_ack_n` high. The enables stay zero and `cpu_stall` stays 1 for that clock. On the next clock the enables are all ones and `cpu_stall` is 0.
- R8: `cpu_stall` is 1 from the commit of a release (entry to DRAIN or GRANT) until the clock after `bus_ack_n` rises.
- R9: The request continues to be sampled while released: low samples keep the release in place for any number of states.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_req_n | input | 1 | Active-low external bus request |
| state_edge | input | 1 | Start-of-bus-state strobe; request sampled when 1 |
| acc_busy | input | 1 | A CPU external access is in progress |
| acc_final | input | 1 | The current state is the last of that access |
| bus_ack_n | output | 1 | Active-low bus acknowledge |
| cpu_stall | output | 1 | Holds the CPU off new external accesses |
| en_addr | output | ADDR_W | Address pin drive enables |
| en_data | output | DATA_W | Data pin drive enables |
| en_cs | output | NUM_CS | Chip-select drive enables |
| en_as | output | 1 | Address strobe drive enable |
| en_rd | output | 1 | Read strobe drive enable |
| en_wrh | output | 1 | High write strobe drive enable |
| en_wrl | output | 1 | Low write strobe drive enable |

## Verification
A wrong state appears at the ports in the clock right after the faulty transition, because every output is decoded directly from the state register.

Different faults leave different signs:

- A skipped qualification stage shows up as an acknowledge one boundary early.
- A lost drain shows up as an acknowledge while `acc_final` is still 0.
- A missing reclaim state shows up as the enables and the acknowledge switching on the same clock.

The scoreboard compares the acknowledge, the stall and every enable bus after each clock. Any such slip is therefore caught on the clock it happens.

// File: rtl/ebr_pkg.sv
package ebr_pkg;
    typedef enum logic [2:0] {
        ST_OWN     = 3'd0,
        ST_QUAL    = 3'd1,
        ST_DRAIN   = 3'd2,
        ST_GRANT   = 3'd3,
        ST_RECLAIM = 3'd4
    } ebr_state_e;
endpackage

// File: rtl/ebr_fsm.sv
module ebr_fsm
    import ebr_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic bus_req_n,
    input  logic state_edge,
    input  logic acc_busy,
    input  logic acc_final,
    output logic ack_n,
    output logic stall,
    output logic drive
);
    ebr_state_e state_q, state_d;
    logic       can_hand;

    // The access may be cut at this boundary if none runs or it ends here.
    assign can_hand = !acc_busy || acc_final;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_OWN;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_OWN: begin
                if (state_edge && !bus_req_n) state_d = ST_QUAL;
            end
            ST_QUAL: begin
                if (state_edge) begin
                    if (bus_req_n)     state_d = ST_OWN;
                    else if (can_hand) state_d = ST_GRANT;
                    else               state_d = ST_DRAIN;
                end
            end
            ST_DRAIN: begin
                if (state_edge && can_hand) state_d = ST_GRANT;
            end
            ST_GRANT: begin
                if (state_edge && bus_req_n) state_d = ST_RECLAIM;
            end
            ST_RECLAIM: state_d = ST_OWN;
            default:    state_d = ST_OWN;
        endcase
    end

    always_comb begin
        ack_n = 1'b1;
        stall = 1'b0;
        drive = 1'b1;
        unique case (state_q)
            ST_OWN, ST_QUAL: ;
            ST_DRAIN: stall = 1'b1;
            ST_GRANT: begin
                ack_n = 1'b0;
                stall = 1'b1;
                drive = 1'b0;
            end
            ST_RECLAIM: begin
                stall = 1'b1;
                drive = 1'b0;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/ebr_pin_enables.sv
module ebr_pin_enables #(
    parameter int ADDR_W = 24,
    parameter int DATA_W = 16,
    parameter int NUM_CS = 8
) (
    input  logic              drive,
    output logic [ADDR_W-1:0] en_addr,
    output logic [DATA_W-1:0] en_data,
    output logic [NUM_CS-1:0] en_cs,
    output logic              en_as,
    output logic              en_rd,
    output logic              en_wrh,
    output logic              en_wrl
);
    assign en_addr = {ADDR_W{drive}};
    assign en_data = {DATA_W{drive}};

    for (genvar i = 0; i < NUM_CS; i++) begin : g_cs
        assign en_cs[i] = drive;
    end

    assign en_as  = drive;
    assign en_rd  = drive;
    assign en_wrh = drive;
    assign en_wrl = drive;
endmodule

// File: rtl/ext_bus_release.sv
module ext_bus_release #(
    parameter int ADDR_W = 24,
    parameter int DATA_W = 16,
    parameter int NUM_CS = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_req_n,
    input  logic              state_edge,
    input  logic              acc_busy,
    input  logic              acc_final,
    output logic              bus_ack_n,
    output logic              cpu_stall,
    output logic [ADDR_W-1:0] en_addr,
    output logic [DATA_W-1:0] en_data,
    output logic [NUM_CS-1:0] en_cs,
    output logic              en_as,
    output logic              en_rd,
    output logic              en_wrh,
    output logic              en_wrl
);
    logic drive;

    ebr_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_req_n (bus_req_n),
        .state_edge(state_edge),
        .acc_busy  (acc_busy),
        .acc_final (acc_final),
        .ack_n     (bus_ack_n),
        .stall     (cpu_stall),
        .drive     (drive)
    );

    ebr_pin_enables #(
        .ADDR_W(ADDR_W),
        .DATA_W(DATA_W),
        .NUM_CS(NUM_CS)
    ) u_pins (
        .drive  (drive),
        .en_addr(en_addr),
        .en_data(en_data),
        .en_cs  (en_cs),
        .en_as  (en_as),
        .en_rd  (en_rd),
        .en_wrh (en_wrh),
        .en_wrl (en_wrl)
    );
endmodule

// File: rtl/ebr_checker.sv
module ebr_checker #(
    parameter int ADDR_W = 24,
    parameter int DATA_W = 16,
    parameter int NUM_CS = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_req_n,
    input logic              state_edge,
    input logic              acc_busy,
    input logic              acc_final,
    input logic              bus_ack_n,
    input logic              cpu_stall,
    input logic [ADDR_W-1:0] en_addr,
    input logic [DATA_W-1:0] en_data,
    input logic [NUM_CS-1:0] en_cs,
    input logic              en_as,
    input logic              en_rd,
    input logic              en_wrh,
    input logic              en_wrl
);
    logic any_en;
    assign any_en = (|en_addr) | (|en_data) | (|en_cs) | en_as | en_rd | en_wrh | en_wrl;

    assert_pins_off_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_ack_n |-> !any_en);

    assert_stall_on_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_ack_n |-> cpu_stall);

    assert_two_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(bus_ack_n) |-> $past(!bus_req_n && state_edge));

    assert_drain_end_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(bus_ack_n) |-> $past(!acc_busy || acc_final));

    assert_reclaim_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_ack_n) |-> (cpu_stall && !any_en));

    assert_edge_only_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !state_edge |=> $stable(bus_ack_n));
endmodule

bind ext_bus_release ebr_checker #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W),
    .NUM_CS(NUM_CS)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_req_n (bus_req_n),
    .state_edge(state_edge),
    .acc_busy  (acc_busy),
    .acc_final (acc_final),
    .bus_ack_n (bus_ack_n),
    .cpu_stall (cpu_stall),
    .en_addr   (en_addr),
    .en_data   (en_data),
    .en_cs     (en_cs),
    .en_as     (en_as),
    .en_rd     (en_rd),
    .en_wrh    (en_wrh),
    .en_wrl    (en_wrl)
);

// File: tb/ext_bus_release_test.sv
module ext_bus_release_test;
    localparam int AW = 24;
    localparam int DW = 16;
    localparam int NC = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bus_req_n = 1'b1;
    logic          state_edge = 1'b0;
    logic          acc_busy = 1'b0;
    logic          acc_final = 1'b0;
    logic          bus_ack_n;
    logic          cpu_stall;
    logic [AW-1:0] en_addr;
    logic [DW-1:0] en_data;
    logic [NC-1:0] en_cs;
    logic          en_as, en_rd, en_wrh, en_wrl;

    typedef struct {
        logic   ack_n;
        logic   stall;
        logic   drv;
        string  tag;
    } exp_t;

    exp_t exp_q[$];
    int   n_cmp = 0;
    int   n_bad = 0;
    bit   done = 0;

    always #5 clk = ~clk;

    ext_bus_release #(.ADDR_W(AW), .DATA_W(DW), .NUM_CS(NC)) uut (
        .clk(clk), .rst_n(rst_n), .bus_req_n(bus_req_n), .state_edge(state_edge),
        .acc_busy(acc_busy), .acc_final(acc_final), .bus_ack_n(bus_ack_n),
        .cpu_stall(cpu_stall), .en_addr(en_addr), .en_data(en_data), .en_cs(en_cs),
        .en_as(en_as), .en_rd(en_rd), .en_wrh(en_wrh), .en_wrl(en_wrl)
    );

    function automatic bit pins_match(input logic drv);
        if (drv)
            return (&en_addr) && (&en_data) && (&en_cs) && en_as && en_rd && en_wrh && en_wrl;
        return !((|en_addr) || (|en_data) || (|en_cs) || en_as || en_rd || en_wrh || en_wrl);
    endfunction

    task automatic compare(input exp_t e);
        n_cmp++;
        if (bus_ack_n !== e.ack_n || cpu_stall !== e.stall || !pins_match(e.drv)) begin
            n_bad++;
            $display("FAIL %s: ack_n=%b stall=%b as=%b cs=%h exp ack_n=%b stall=%b drive=%b",
                     e.tag, bus_ack_n, cpu_stall, en_as, en_cs, e.ack_n, e.stall, e.drv);
        end
    endtask

    // Driver: apply one clock of stimulus and queue the expected outputs after that edge.
    task automatic step(input logic req_n, input logic edge_i, input logic busy, input logic fin,
                        input logic x_ack, input logic x_stall, input logic x_drv, input string tag);
        exp_t e;
        @(negedge clk);
        bus_req_n  = req_n;
        state_edge = edge_i;
        acc_busy   = busy;
        acc_final  = fin;
        e.ack_n = x_ack; e.stall = x_stall; e.drv = x_drv; e.tag = tag;
        exp_q.push_back(e);
    endtask

    // Monitor
    always @(posedge clk) begin
        #2;
        if (rst_n && exp_q.size() > 0) compare(exp_q.pop_front());
    end

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        exp_t r;
        repeat (3) @(posedge clk);
        #2;
        r.ack_n = 1; r.stall = 0; r.drv = 1; r.tag = "R1 during reset";
        compare(r);
        @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk); #2;
        r.tag = "R1 after reset";
        compare(r);

        // R4 idle CPU: qualify then grant; R9 stays granted; R7 reclaim
        step(0, 1, 0, 0, 1, 0, 1, "R4 first low sample");
        step(0, 1, 0, 0, 0, 1, 0, "R4 grant after second sample");
        step(0, 1, 0, 0, 0, 1, 0, "R9 still released");
        step(0, 1, 1, 0, 0, 1, 0, "R9 released, access flags ignored");
        step(1, 1, 0, 0, 1, 1, 0, "R7 ack high, pins off");
        step(1, 1, 0, 0, 1, 0, 1, "R7 pins back, stall off");

        // R3 single low then high
        step(0, 1, 0, 0, 1, 0, 1, "R3 single low");
        step(1, 1, 0, 0, 1, 0, 1, "R3 high restarts");
        step(0, 1, 0, 0, 1, 0, 1, "R3 low again, first only");
        step(1, 1, 0, 0, 1, 0, 1, "R3 no release");
        step(1, 1, 0, 0, 1, 0, 1, "R3 idle");

        // R5 access in progress, R8 stall during drain
        step(0, 1, 1, 0, 1, 0, 1, "R5 first sample mid access");
        step(0, 1, 1, 0, 1, 1, 1, "R8 committed, drain");
        step(0, 1, 1, 0, 1, 1, 1, "R5 still draining");
        step(0, 1, 1, 1, 0, 1, 0, "R5 grant at final state");
        step(1, 1, 0, 0, 1, 1, 0, "R8 reclaim stall held");
        step(1, 1, 0, 0, 1, 0, 1, "R8 stall dropped");

        // R5 access ends at qualifying boundary
        step(0, 1, 1, 0, 1, 0, 1, "R5 first sample");
        step(0, 1, 1, 1, 0, 1, 0, "R5 final at second sample");
        step(1, 1, 0, 0, 1, 1, 0, "R7 reclaim");
        step(1, 1, 0, 0, 1, 0, 1, "R7 owned");

        // R2 no sampling without state_edge
        step(0, 0, 0, 0, 1, 0, 1, "R2 low ignored off-edge");
        step(0, 0, 0, 0, 1, 0, 1, "R2 low ignored off-edge again");
        step(0, 1, 0, 0, 1, 0, 1, "R2 first real sample");
        step(0, 0, 0, 0, 1, 0, 1, "R2 gap keeps qualify");
        step(0, 1, 0, 0, 0, 1, 0, "R2 grant on second edge");
        step(1, 0, 0, 0, 0, 1, 0, "R2 high off-edge ignored");
        step(1, 1, 0, 0, 1, 1, 0, "R7 reclaim on edge");
        step(1, 0, 0, 0, 1, 0, 1, "R7 owned without edge");
        step(1, 1, 0, 0, 1, 0, 1, "R1 quiet");

        repeat (3) @(posedge clk);
        #3;
        done = 1;
        summary();
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            summary();
        end
    end
endmodule